// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Controller

This block keeps a four-row DRAM array refreshed. An interval timer, clocked from the host clock with a programmable divisor, marks each point at which a refresh falls due. Each due refresh is added to a small count of owed refreshes. While any refresh is owed, the block raises a request to the main DRAM sequencer. When the sequencer acknowledges, the block runs one CAS-before-RAS cycle on every populated row. An extended setting multiplies the divisor by sixteen. With this setting, the 15.6 µs standard period can be stretched to roughly 250 µs.

A suspend input selects how the array is kept alive while the system sleeps. If self-refresh is not enabled, the periodic refresh simply continues. If self-refresh is enabled, the block runs one CAS-before-RAS cycle without waiting for the sequencer and then holds CAS and RAS low, which leaves the DRAM refreshing itself. When suspend is released, RAS is raised before CAS. After the precharge time, one refresh burst is issued at once, and periodic operation then resumes.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is high, every RAS and CAS strobe is high (inactive), the request is low and the owed count is 0.
- R2: With the extended setting low, a refresh falls due every `refresh_div_i` clocks, counted from reset or from the end of self-refresh. With the extended setting high, one falls due every 16 × `refresh_div_i` clocks. The request rises in the clock after the last counted edge.
- R3: The request is high exactly when at least one refresh is owed and the block is idle. An acknowledge sampled while the request is high has these effects on the next clock: the request drops, the owed count goes down by one, and a refresh cycle starts. When the cycle ends with refreshes still owed, the request rises again.
- R4: A refresh cycle drives all CAS lines low for one clock with RAS high. It then drives RAS low, together with CAS, for RAS_CLKS clocks (default 3). It then holds every strobe high for PRE_CLKS clocks (default 2).
- R5: RAS line i goes low only when bit i of `row_present_i` is 1. Unpopulated rows keep RAS high throughout refresh and self-refresh.
- R6: The owed count rises by one for each due refresh that has not yet been served. It saturates at MAX_OWED (default 4).
- R7: While suspend is high and self-refresh is disabled, periodic requests keep being produced as in normal operation.
- R8: Suspend and self-refresh enable are both high while the block is idle and no acknowledge is accepted. In that case the owed count is cleared, CAS falls for one clock, and then RAS falls on populated rows. Both are then held low with `self_ref_o` high and no request, and the interval timer is held.
- R9: When suspend falls during self-refresh, the block takes these steps in order:
  - it raises RAS for one clock while CAS stays low;
  - it holds every strobe high for PRE_CLKS clocks;
  - it runs one full refresh cycle without any acknowledge.
  The interval timer then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_div_i | input | DIV_W | Clocks per refresh period (must be nonzero) |
| ext_period_i | input | 1 | Multiply the period by 2^EXT_SHIFT (16) |
| row_present_i | input | NUM_ROWS | Populated-row mask, bit i for row i |
| suspend_i | input | 1 | System suspend |
| self_ref_en_i | input | 1 | Use self-refresh while suspended |
| ref_ack_i | input | 1 | Sequencer grants the DRAM for one refresh |
| ref_req_o | output | 1 | Refresh request to the sequencer |
| ras_n_o | output | NUM_ROWS | Row strobes, active low |
| cas_n_o | output | NUM_CAS | Column strobes, active low |
| owed_o | output | OW | Number of refreshes owed |
| self_ref_o | output | 1 | DRAM is held in self-refresh |

## Verification
Several rules are checked by the assertions on every clock:
- any RAS fall is preceded by a clock with CAS low;
- an unpopulated row never sees RAS low;
- the request only appears with all strobes idle;
- an accepted acknowledge starts a cycle on the next clock;
- the owed count never passes its limit;
- leaving self-refresh always raises RAS while CAS is still low.

Other behaviour can only be shown by the bench's scenarios, which check each of these against computed clock numbers:
- the exact period length in normal and extended settings;
- saturation after several missed periods;
- the draining of owed refreshes;
- the timer being frozen during self-refresh;
- the timing of the burst refresh after wake-up.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS,
    ST_RAS,
    ST_PRE,
    ST_SELF,
    ST_XRAS
  } ref_state_e;

  typedef enum logic [1:0] {
    SP_OFF,
    SP_IN,
    SP_X1,
    SP_X2
  } sr_phase_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int DIV_W     = 16,
  parameter int EXT_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_i,
  input  logic             hold_i,
  output logic             tick_o
);
  localparam int LW = DIV_W + EXT_SHIFT;

  logic [LW-1:0] cnt;
  logic [LW-1:0] limit;

  always_comb begin
    if (ext_i) limit = {div_i, {EXT_SHIFT{1'b0}}};
    else       limit = LW'(div_i);
  end

  // >= keeps the timer safe if the divisor shrinks mid-count
  assign tick_o = !hold_i && (cnt >= limit - LW'(1));

  always_ff @(posedge clk) begin
    if (rst || hold_i)  cnt <= '0;
    else if (tick_o)    cnt <= '0;
    else                cnt <= cnt + LW'(1);
  end

  // R8: a held timer never completes a period
  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    $past(hold_i) |-> cnt <= LW'(1));
endmodule

// File: rtl/refresh_owed_counter.sv
module refresh_owed_counter #(
  parameter int MAX_OWED = 4,
  parameter int OW       = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          take_i,
  input  logic          clr_i,
  output logic [OW-1:0] owed_o,
  output logic [OW-1:0] owed_nx_o
);
  always_comb begin
    owed_nx_o = owed_o;
    if (clr_i) begin
      owed_nx_o = '0;
    end else begin
      case ({tick_i, take_i})
        2'b10: if (owed_o != OW'(MAX_OWED)) owed_nx_o = owed_o + OW'(1);
        2'b01: if (owed_o != '0)            owed_nx_o = owed_o - OW'(1);
        default: owed_nx_o = owed_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owed_o <= '0;
    else     owed_o <= owed_nx_o;
  end

  a_r6_owed_bound: assert property (@(posedge clk) disable iff (rst)
    owed_o <= OW'(MAX_OWED));

  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (owed_o == OW'(MAX_OWED) && tick_i && !take_i && !clr_i) |=> owed_o == OW'(MAX_OWED));

  a_r3_take_decrements: assert property (@(posedge clk) disable iff (rst)
    (take_i && !tick_i && !clr_i) |=> owed_o == $past(owed_o) - OW'(1));
endmodule

// File: rtl/refresh_strobe_fsm.sv
module refresh_strobe_fsm
  import dram_refresh_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_CAS  = 8,
  parameter int RAS_CLKS = 3,
  parameter int PRE_CLKS = 2,
  parameter int OW       = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ack_i,
  input  logic                suspend_i,
  input  logic                self_en_i,
  input  logic [NUM_ROWS-1:0] row_present_i,
  input  logic [OW-1:0]       owed_nx_i,
  output logic                req_o,
  output logic                take_o,
  output logic                clr_o,
  output logic                hold_o,
  output logic [NUM_ROWS-1:0] ras_n_o,
  output logic [NUM_CAS-1:0]  cas_n_o,
  output logic                self_o
);
  localparam int PMAX = (RAS_CLKS > PRE_CLKS) ? RAS_CLKS : PRE_CLKS;
  localparam int PCW  = $clog2(PMAX + 1);

  ref_state_e st, st_nx;
  sr_phase_e  sp, sp_nx;
  logic [PCW-1:0] pc, pc_nx;

  always_comb begin
    st_nx  = st;
    sp_nx  = sp;
    pc_nx  = pc;
    take_o = 1'b0;
    clr_o  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_o && ack_i) begin
          take_o = 1'b1;
          st_nx  = ST_CAS;
        end else if (suspend_i && self_en_i) begin
          clr_o = 1'b1;
          st_nx = ST_CAS;
          sp_nx = SP_IN;
        end
      end
      ST_CAS: begin
        st_nx = ST_RAS;
        pc_nx = '0;
      end
      ST_RAS: begin
        if (pc == PCW'(RAS_CLKS - 1)) begin
          pc_nx = '0;
          st_nx = (sp == SP_IN) ? ST_SELF : ST_PRE;
        end else begin
          pc_nx = pc + PCW'(1);
        end
      end
      ST_PRE: begin
        if (pc == PCW'(PRE_CLKS - 1)) begin
          pc_nx = '0;
          if (sp == SP_X1) begin
            st_nx = ST_CAS;
            sp_nx = SP_X2;
          end else begin
            st_nx = ST_IDLE;
            sp_nx = SP_OFF;
          end
        end else begin
          pc_nx = pc + PCW'(1);
        end
      end
      ST_SELF: begin
        if (!suspend_i) begin
          st_nx = ST_XRAS;
          sp_nx = SP_X1;
        end
      end
      ST_XRAS: begin
        st_nx = ST_PRE;
        pc_nx = '0;
      end
      default: begin
        st_nx = ST_IDLE;
        sp_nx = SP_OFF;
      end
    endcase
  end

  assign hold_o = (sp_nx != SP_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sp      <= SP_OFF;
      pc      <= '0;
      req_o   <= 1'b0;
      ras_n_o <= '1;
      cas_n_o <= '1;
      self_o  <= 1'b0;
    end else begin
      st      <= st_nx;
      sp      <= sp_nx;
      pc      <= pc_nx;
      req_o   <= (owed_nx_i != '0) && (st_nx == ST_IDLE) && (sp_nx == SP_OFF);
      cas_n_o <= (st_nx inside {ST_CAS, ST_RAS, ST_SELF, ST_XRAS}) ? '0 : '1;
      ras_n_o <= (st_nx inside {ST_RAS, ST_SELF}) ? ~row_present_i : '1;
      self_o  <= (st_nx == ST_SELF);
    end
  end

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    ($past(ras_n_o) == '1 && ras_n_o != '1) |-> $past(cas_n_o) == '0);

  a_r4_cas_together: assert property (@(posedge clk) disable iff (rst)
    (cas_n_o == '0) || (cas_n_o == '1));

  a_r5_unpopulated_high: assert property (@(posedge clk) disable iff (rst)
    (~ras_n_o & ~$past(row_present_i)) == '0);

  a_r3_req_when_idle: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (cas_n_o == '1 && ras_n_o == '1));

  a_r3_ack_starts_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> (!req_o && cas_n_o == '0 && ras_n_o == '1));

  a_r8_self_strobes: assert property (@(posedge clk) disable iff (rst)
    self_o |-> (cas_n_o == '0 && !req_o));

  a_r9_exit_ras_first: assert property (@(posedge clk) disable iff (rst)
    ($past(self_o) && !self_o) |-> (ras_n_o == '1 && cas_n_o == '0));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int DIV_W     = 16,
  parameter int EXT_SHIFT = 4,
  parameter int NUM_ROWS  = 4,
  parameter int NUM_CAS   = 8,
  parameter int RAS_CLKS  = 3,
  parameter int PRE_CLKS  = 2,
  parameter int MAX_OWED  = 4,
  parameter int OW        = $clog2(MAX_OWED + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    refresh_div_i,
  input  logic                ext_period_i,
  input  logic [NUM_ROWS-1:0] row_present_i,
  input  logic                suspend_i,
  input  logic                self_ref_en_i,
  input  logic                ref_ack_i,
  output logic                ref_req_o,
  output logic [NUM_ROWS-1:0] ras_n_o,
  output logic [NUM_CAS-1:0]  cas_n_o,
  output logic [OW-1:0]       owed_o,
  output logic                self_ref_o
);
  logic          tick, take, clr, hold;
  logic [OW-1:0] owed_nx;

  refresh_interval_timer #(
    .DIV_W     (DIV_W),
    .EXT_SHIFT (EXT_SHIFT)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .div_i  (refresh_div_i),
    .ext_i  (ext_period_i),
    .hold_i (hold),
    .tick_o (tick)
  );

  refresh_owed_counter #(
    .MAX_OWED (MAX_OWED),
    .OW       (OW)
  ) u_owed (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .take_i    (take),
    .clr_i     (clr),
    .owed_o    (owed_o),
    .owed_nx_o (owed_nx)
  );

  refresh_strobe_fsm #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_CAS  (NUM_CAS),
    .RAS_CLKS (RAS_CLKS),
    .PRE_CLKS (PRE_CLKS),
    .OW       (OW)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .ack_i         (ref_ack_i),
    .suspend_i     (suspend_i),
    .self_en_i     (self_ref_en_i),
    .row_present_i (row_present_i),
    .owed_nx_i     (owed_nx),
    .req_o         (ref_req_o),
    .take_o        (take),
    .clr_o         (clr),
    .hold_o        (hold),
    .ras_n_o       (ras_n_o),
    .cas_n_o       (cas_n_o),
    .self_o        (self_ref_o)
  );
endmodule

// File: tb/dram_refresh_ctrl_test.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_test;
  typedef struct {
    int         cyc;
    logic [3:0] ras;
    logic [7:0] cas;
    logic       req;
    logic [2:0] owed;
    logic       slf;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div = 16'd10;
  logic        ext = 1'b0;
  logic [3:0]  present = 4'hF;
  logic        suspend = 1'b0;
  logic        sre = 1'b0;
  logic        ack = 1'b0;
  logic        req;
  logic [3:0]  ras_n;
  logic [7:0]  cas_n;
  logic [2:0]  owed;
  logic        slf;

  int   cyc = 0;
  int   compared = 0;
  int   mismatched = 0;
  int   r0 = 0;
  bit   finished = 0;
  exp_t sbq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_ctrl uut (
    .clk           (clk),
    .rst           (rst),
    .refresh_div_i (div),
    .ext_period_i  (ext),
    .row_present_i (present),
    .suspend_i     (suspend),
    .self_ref_en_i (sre),
    .ref_ack_i     (ack),
    .ref_req_o     (req),
    .ras_n_o       (ras_n),
    .cas_n_o       (cas_n),
    .owed_o        (owed),
    .self_ref_o    (slf)
  );

  task automatic push(input int c, input logic [3:0] r, input logic [7:0] k,
                      input logic q, input logic [2:0] o, input logic s, input string t);
    exp_t e;
    e.cyc = c; e.ras = r; e.cas = k; e.req = q; e.owed = o; e.slf = s; e.tag = t;
    sbq.push_back(e);
  endtask

  // monitor: pops expectations due in this cycle
  always @(negedge clk) begin
    if (!finished) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        compared++;
        if (e.cyc < cyc) begin
          mismatched++;
          $display("FAIL %s: sample at cycle %0d missed (now %0d)", e.tag, e.cyc, cyc);
        end else if (ras_n !== e.ras || cas_n !== e.cas || req !== e.req ||
                     owed !== e.owed || slf !== e.slf) begin
          mismatched++;
          $display("FAIL %s @%0d: got ras=%b cas=%b req=%b owed=%0d self=%b, expected ras=%b cas=%b req=%b owed=%0d self=%b",
                   e.tag, cyc, ras_n, cas_n, req, owed, slf, e.ras, e.cas, e.req, e.owed, e.slf);
        end
      end
    end
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    push(cyc + 1, 4'hF, 8'hFF, 1'b0, 3'd0, 1'b0, "R1 reset state");
    @(negedge clk);
    rst = 1'b0;
    r0 = cyc;
  endtask

  // acknowledge now; expect one full refresh cycle (R3, R4, R5)
  task automatic ack_and_expect(input logic [3:0] mask, input logic [2:0] owed_after);
    int c;
    c = cyc;
    ack = 1'b1;
    push(c + 1, 4'hF,  8'h00, 1'b0, owed_after, 1'b0, "R3/R4 ack starts with CAS only");
    push(c + 2, ~mask, 8'h00, 1'b0, owed_after, 1'b0, "R4/R5 RAS low on populated rows");
    push(c + 4, ~mask, 8'h00, 1'b0, owed_after, 1'b0, "R4 RAS still low at last clock");
    push(c + 5, 4'hF,  8'hFF, 1'b0, owed_after, 1'b0, "R4 precharge begins");
    push(c + 6, 4'hF,  8'hFF, 1'b0, owed_after, 1'b0, "R4 precharge second clock");
    push(c + 7, 4'hF,  8'hFF, owed_after != 0, owed_after, 1'b0, "R3 request after cycle");
    @(negedge clk);
    ack = 1'b0;
    wait_to(c + 7);
  endtask

  initial begin
    int s;
    int x;
    // normal periodic refresh, interval 10
    do_reset();
    push(r0 + 9,  4'hF, 8'hFF, 1'b0, 3'd0, 1'b0, "R2 no request before the period");
    push(r0 + 10, 4'hF, 8'hFF, 1'b1, 3'd1, 1'b0, "R2 request after the period");
    push(r0 + 20, 4'hF, 8'hFF, 1'b1, 3'd2, 1'b0, "R6 second owed refresh");
    push(r0 + 40, 4'hF, 8'hFF, 1'b1, 3'd4, 1'b0, "R6 four owed");
    push(r0 + 50, 4'hF, 8'hFF, 1'b1, 3'd4, 1'b0, "R6 saturates at four");
    wait_to(r0 + 51);
    div = 16'd1000;
    ack_and_expect(4'hF, 3'd3);
    // drain with a partial population
    present = 4'b0101;
    ack_and_expect(4'b0101, 3'd2);
    ack_and_expect(4'b0101, 3'd1);
    ack_and_expect(4'b0101, 3'd0);

    // extended period while suspended without self-refresh
    div = 16'd4; ext = 1'b1; suspend = 1'b1; sre = 1'b0; present = 4'b0111;
    do_reset();
    push(r0 + 63, 4'hF, 8'hFF, 1'b0, 3'd0, 1'b0, "R2 extended period not yet over");
    push(r0 + 64, 4'hF, 8'hFF, 1'b1, 3'd1, 1'b0, "R7 extended request during suspend");
    wait_to(r0 + 64);

    // self-refresh entry with one refresh owed
    s = cyc;
    sre = 1'b1;
    push(s + 1,   4'hF,    8'h00, 1'b0, 3'd0, 1'b0, "R8 entry CAS first, owed cleared");
    push(s + 2,   4'b1000, 8'h00, 1'b0, 3'd0, 1'b0, "R8 entry RAS");
    push(s + 5,   4'b1000, 8'h00, 1'b0, 3'd0, 1'b1, "R8 strobes held low");
    push(s + 150, 4'b1000, 8'h00, 1'b0, 3'd0, 1'b1, "R8 timer held in self-refresh");
    wait_to(s + 150);

    // exit
    x = cyc;
    suspend = 1'b0; sre = 1'b0;
    push(x + 1,  4'hF,    8'h00, 1'b0, 3'd0, 1'b0, "R9 RAS rises before CAS");
    push(x + 2,  4'hF,    8'hFF, 1'b0, 3'd0, 1'b0, "R9 precharge after exit");
    push(x + 4,  4'hF,    8'h00, 1'b0, 3'd0, 1'b0, "R9 burst CAS without ack");
    push(x + 5,  4'b1000, 8'h00, 1'b0, 3'd0, 1'b0, "R9 burst RAS");
    push(x + 8,  4'hF,    8'hFF, 1'b0, 3'd0, 1'b0, "R9 burst precharge");
    push(x + 72, 4'hF,    8'hFF, 1'b0, 3'd0, 1'b0, "R9 timer restarted from zero");
    push(x + 73, 4'hF,    8'hFF, 1'b1, 3'd1, 1'b0, "R9 first period after exit");
    wait_to(x + 80);

    if (sbq.size() != 0) begin
      mismatched += sbq.size();
      compared += sbq.size();
      $display("FAIL scoreboard: %0d expectations never sampled", sbq.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule